// File: doc/BRIEF.md
# Control-Register Port Handshake Master

This block drives the internal control-register port of a PHY. A client hands it one register access at a time: a write or a read, each with a 16-bit register address and, for a write, 16-bit data. The block turns the access into a series of phases on a parallel command word. Each phase has a 16-bit value field and one of four strobes: address capture, data capture, read and write. The block watches the acknowledge bit of the PHY's response word and reports the result.

Each phase is a full four-phase handshake. The value is placed on the bus with no strobe. Then the strobe is raised and the block waits for acknowledge to rise. Then the strobe is dropped with the value still held, and the block waits for acknowledge to fall. A write runs address capture, data capture and the write strobe, in that order. A read runs address capture and then the read strobe. During the read phase the response data is latched while acknowledge is high.

Every wait is bounded by a microsecond limit, counted on a tick divided down from the system clock. When a wait expires, the access is abandoned and the block reports which kind of wait failed.

Top module: `crport_master`

## Requirements
- R1: While `rst_ni` is low, `busy_o`, `done_o` and `err_o` are low and `cmd_o` is all zero, and this holds immediately, even in the middle of an access.
- R2: `cmd_o` bit 0 is the address-capture strobe, bit 1 the data-capture strobe, bits [17:2] the 16-bit value, bit 18 the read strobe and bit 19 the write strobe. At most one strobe is high in any cycle.
- R3: Every strobe rises only after a cycle in which the same value was already on bits [17:2] with all strobes low. The strobe stays high until `rsp_i[0]` (acknowledge) is seen high, or until a timeout occurs.
- R4: A write raises address capture with the address, then data capture with the data, then the write strobe with the data still in the value field.
- R5: A read raises address capture with the address, then the read strobe. `rdata_o` takes `rsp_i[16:1]` as sampled while acknowledge is high in the read phase, and is valid when `done_o` pulses.
- R6: If acknowledge does not rise within the limit after a strobe is raised, the access stops. All strobes go low, `err_o` pulses with `err_code_o` = 2'b01, and no further strobe is raised.
- R7: If acknowledge does not fall within the limit after a strobe is dropped, the access stops. `err_o` pulses with `err_code_o` = 2'b10, and no further strobe is raised.
- R8: `req_valid_i` is accepted only while `busy_o` is low. A request presented while busy has no effect on the access in progress and is not queued.
- R9: `busy_o` is high from the cycle after acceptance until the cycle in which `done_o` or `err_o` pulses. In that cycle it is low. `done_o` and `err_o` each last one cycle and are never high together.
- R10: A wait expires no sooner than (TIMEOUT_US-1)*CLK_PER_US and no later than (TIMEOUT_US+1)*CLK_PER_US clock cycles after it begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_write_i | input | 1 | 1 = register write, 0 = register read |
| req_addr_i | input | 16 | Register address |
| req_wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle pulse: access completed |
| err_o | output | 1 | One-cycle pulse: access aborted on timeout |
| err_code_o | output | 2 | 01 rising-acknowledge timeout, 10 falling-acknowledge timeout, 00 none |
| rdata_o | output | 16 | Data returned by the last read |
| cmd_o | output | 20 | Command word to the PHY port |
| rsp_i | input | 17 | Response word: bit 0 acknowledge, [16:1] read data |

## Verification
The checks on strobe drop assume that the PHY raises acknowledge only in answer to a strobe and lowers it only after the strobe has gone. They also assume that the response data is stable while acknowledge is high. The bench's PHY model keeps to this rule, with a programmable delay in each direction. It breaks the rule only through two switches: one never answers, and one never releases. These switches drive the rising and falling timeout paths. Requests are held stable for their single accept cycle. Extra requests are raised only while an access is running, to show that they are dropped.

// File: rtl/crport_pkg.sv
`timescale 1ns/1ps
package crport_pkg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned NUM_STB = 4;

  // strobe index; also the strobe's slot in the engine's strobe vector
  typedef enum logic [1:0] {
    STB_ADDR  = 2'd0,
    STB_DATA  = 2'd1,
    STB_READ  = 2'd2,
    STB_WRITE = 2'd3
  } stb_sel_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'b00,
    ERR_RISE = 2'b01,
    ERR_FALL = 2'b10
  } err_code_e;
endpackage

// File: rtl/crport_tick.sv
`timescale 1ns/1ps
module crport_tick #(
  parameter int unsigned CLK_PER_US = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned DIV_W   = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [DIV_W-1:0] DIV_MAX = DIV_W'(CLK_PER_US - 1);

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               div_q <= '0;
    else if (div_q == DIV_MAX) div_q <= '0;
    else                       div_q <= div_q + 1'b1;
  end

  assign tick_o = (div_q == DIV_MAX);
endmodule

// File: rtl/crport_phase.sv
`timescale 1ns/1ps
module crport_phase
  import crport_pkg::*;
#(
  parameter int unsigned TIMEOUT_US = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] value_i,
  input  stb_sel_e          sel_i,
  input  logic              ack_i,
  output logic [DATA_W-1:0] value_o,
  output logic [NUM_STB-1:0] stb_o,
  output logic              cap_o,
  output logic              fin_o,
  output logic              to_rise_o,
  output logic              to_fall_o
);
  localparam int unsigned CNT_W = $clog2(TIMEOUT_US + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_US - 1);

  typedef enum logic [1:0] {E_IDLE, E_SETUP, E_RISE, E_FALL} eng_state_e;

  eng_state_e        state_q;
  logic [DATA_W-1:0] value_q;
  stb_sel_e          sel_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              expire;

  assign expire    = tick_i && (cnt_q == CNT_LAST);
  assign cap_o     = (state_q == E_RISE) && ack_i;
  assign fin_o     = (state_q == E_FALL) && !ack_i;
  assign to_rise_o = (state_q == E_RISE) && !ack_i && expire;
  assign to_fall_o = (state_q == E_FALL) && ack_i && expire;
  assign value_o   = value_q;

  always_comb begin
    stb_o = '0;
    if (state_q == E_RISE) stb_o[sel_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= E_IDLE;
      value_q <= '0;
      sel_q   <= STB_ADDR;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        E_IDLE: if (start_i) begin
          value_q <= value_i;
          sel_q   <= sel_i;
          state_q <= E_SETUP;
        end
        // value alone on the bus for one cycle
        E_SETUP: begin
          cnt_q   <= '0;
          state_q <= E_RISE;
        end
        E_RISE: begin
          if (ack_i) begin
            cnt_q   <= '0;
            state_q <= E_FALL;
          end else if (expire) state_q <= E_IDLE;
          else if (tick_i)     cnt_q   <= cnt_q + 1'b1;
        end
        E_FALL: begin
          if (!ack_i)          state_q <= E_IDLE;
          else if (expire)     state_q <= E_IDLE;
          else if (tick_i)     cnt_q   <= cnt_q + 1'b1;
        end
        default: state_q <= E_IDLE;
      endcase
    end
  end

  // R2
  stb_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stb_o));

  // R3
  setup_before_stb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|stb_o) |-> $stable(value_q));

  // R3
  drop_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(|stb_o) |-> ($past(ack_i) || $past(to_rise_o)));
endmodule

// File: rtl/crport_master.sv
`timescale 1ns/1ps
module crport_master
  import crport_pkg::*;
#(
  parameter int unsigned CLK_PER_US = 200,
  parameter int unsigned TIMEOUT_US = 100
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic                req_write_i,
  input  logic [DATA_W-1:0]   req_addr_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                err_o,
  output logic [1:0]          err_code_o,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [DATA_W+3:0]   cmd_o,
  input  logic [DATA_W:0]     rsp_i
);
  typedef enum logic [1:0] {T_IDLE, T_LAUNCH, T_WAIT} top_state_e;

  top_state_e         state_q;
  logic [1:0]         ph_q;
  logic               wr_q;
  logic [DATA_W-1:0]  addr_q, wdata_q, rdata_q;
  logic               done_q, err_q;
  err_code_e          err_code_q;

  logic [DATA_W-1:0]  ph_value;
  stb_sel_e           ph_sel;
  logic               ph_last;

  logic               tick;
  logic [DATA_W-1:0]  eng_value;
  logic [NUM_STB-1:0] eng_stb;
  logic               eng_cap, eng_fin, eng_to_rise, eng_to_fall;
  logic               ack;

  assign ack = rsp_i[0];

  crport_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  crport_phase #(.TIMEOUT_US(TIMEOUT_US)) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .start_i   (state_q == T_LAUNCH),
    .value_i   (ph_value),
    .sel_i     (ph_sel),
    .ack_i     (ack),
    .value_o   (eng_value),
    .stb_o     (eng_stb),
    .cap_o     (eng_cap),
    .fin_o     (eng_fin),
    .to_rise_o (eng_to_rise),
    .to_fall_o (eng_to_fall)
  );

  // phase list: write = addr, data, write; read = addr, read
  always_comb begin
    ph_value = addr_q;
    ph_sel   = STB_ADDR;
    ph_last  = 1'b0;
    case (ph_q)
      2'd0: ph_last = 1'b0;
      2'd1: begin
        if (wr_q) begin
          ph_value = wdata_q;
          ph_sel   = STB_DATA;
        end else begin
          ph_sel   = STB_READ;
          ph_last  = 1'b1;
        end
      end
      default: begin
        ph_value = wdata_q;
        ph_sel   = STB_WRITE;
        ph_last  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= T_IDLE;
      ph_q       <= '0;
      wr_q       <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
      rdata_q    <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      err_code_q <= ERR_NONE;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        T_IDLE: if (req_valid_i) begin
          wr_q       <= req_write_i;
          addr_q     <= req_addr_i;
          wdata_q    <= req_wdata_i;
          ph_q       <= '0;
          err_code_q <= ERR_NONE;
          state_q    <= T_LAUNCH;
        end
        T_LAUNCH: state_q <= T_WAIT;
        T_WAIT: begin
          if (eng_to_rise || eng_to_fall) begin
            err_q      <= 1'b1;
            err_code_q <= eng_to_rise ? ERR_RISE : ERR_FALL;
            state_q    <= T_IDLE;
          end else if (eng_fin) begin
            if (ph_last) begin
              done_q  <= 1'b1;
              state_q <= T_IDLE;
            end else begin
              ph_q    <= ph_q + 1'b1;
              state_q <= T_LAUNCH;
            end
          end
        end
        default: state_q <= T_IDLE;
      endcase
      if (eng_cap && (ph_sel == STB_READ)) rdata_q <= rsp_i[DATA_W:1];
    end
  end

  assign busy_o     = (state_q != T_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign err_code_o = err_code_q;
  assign rdata_o    = rdata_q;
  assign cmd_o      = {eng_stb[STB_WRITE], eng_stb[STB_READ], eng_value,
                       eng_stb[STB_DATA], eng_stb[STB_ADDR]};

  // R9
  done_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> !busy_o);

  // R9
  single_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, err_o}));

  // R6
  err_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (eng_stb == '0));

  // R8
  accept_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_valid_i));
endmodule

// File: tb/tb_crport_master.sv
`timescale 1ns/1ps
module tb_crport_master;
  localparam int unsigned C  = 4;
  localparam int unsigned TU = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic busy_o, done_o, err_o;
  logic [1:0] err_code_o;
  logic [15:0] rdata_o;
  logic [19:0] cmd_o;
  logic ack;
  logic [15:0] dout;

  always #2.5 clk = ~clk;

  crport_master #(.CLK_PER_US(C), .TIMEOUT_US(TU)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .busy_o(busy_o), .done_o(done_o),
    .err_o(err_o), .err_code_o(err_code_o), .rdata_o(rdata_o), .cmd_o(cmd_o),
    .rsp_i({dout, ack})
  );

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc++;

  // PHY model knobs (written by the stimulus only)
  int dly = 0, txn_id = 0;
  bit no_ack = 0, stuck = 0;

  // PHY model state (written by the model only)
  logic [15:0] mem [16];
  logic [1:0]  log_kind [8];
  logic [15:0] log_val [8];
  bit          log_setup [8];
  int log_n = 0, seen_id = 0, dcnt = 0, multi_stb = 0, rise_cyc = 0;
  logic [3:0]  prev_stb = '0;
  logic [15:0] prev_val = '0, m_addr = '0;

  always @(negedge clk) begin
    logic [3:0] stb;
    logic [15:0] val;
    stb = {cmd_o[19], cmd_o[18], cmd_o[1], cmd_o[0]};
    val = cmd_o[17:2];
    if (!rst_n) begin
      ack = 0; dout = '0; dcnt = 0; prev_stb = '0; prev_val = '0;
      for (int i = 0; i < 16; i++) mem[i] = 16'(i * 16'h1111);
    end else begin
      if (seen_id != txn_id) begin log_n = 0; seen_id = txn_id; end
      if ($countones(stb) > 1) multi_stb++;
      for (int b = 0; b < 4; b++) begin
        if (stb[b] && !prev_stb[b]) begin
          if (log_n < 8) begin
            log_kind[log_n]  = 2'(b);
            log_val[log_n]   = val;
            log_setup[log_n] = (val == prev_val) && (prev_stb == '0);
            log_n++;
          end
          rise_cyc = cyc;
          case (b)
            0: m_addr = val;
            2: dout = mem[m_addr[3:0]];
            3: mem[m_addr[3:0]] = val;
            default: ;
          endcase
        end
      end
      if (!ack && (|stb) && !no_ack) begin
        if (dcnt >= dly) begin ack = 1; dcnt = 0; end else dcnt++;
      end else if (ack && !(|stb) && !stuck) begin
        if (dcnt >= dly) begin ack = 0; dcnt = 0; end else dcnt++;
      end else dcnt = 0;
      prev_stb = stb;
      prev_val = val;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_txn(input logic wr, input logic [15:0] a, input logic [15:0] d,
                        output bit got_done, output bit got_err, output int gaps, output int lat);
    txn_id++;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    got_done = 0; got_err = 0; gaps = 0; lat = 0;
    while (!got_done && !got_err && lat < 3000) begin
      if (done_o) got_done = 1;
      else if (err_o) got_err = 1;
      else begin
        if (!busy_o) gaps++;
        @(negedge clk);
        lat++;
      end
    end
  endtask

  // {write, addr, data, ack delay}
  localparam logic [36:0] VECS [6] = '{
    {1'b1, 16'h0015, 16'h1409, 4'd0},
    {1'b1, 16'h0012, 16'hA000, 4'd3},
    {1'b0, 16'h0015, 16'h0000, 4'd1},
    {1'b0, 16'h0003, 16'h0000, 4'd2},
    {1'b1, 16'h1010, 16'h0080, 4'd5},
    {1'b0, 16'h1010, 16'h0000, 4'd0}
  };

  initial begin
    logic [15:0] shadow [16];
    bit gd, ge;
    int gaps, lat, t0;
    for (int i = 0; i < 16; i++) shadow[i] = 16'(i * 16'h1111);

    // R1 reset state
    #1;
    chk(busy_o == 0 && done_o == 0 && err_o == 0, "R1 status in reset", {busy_o, done_o, err_o}, 0);
    chk(cmd_o == '0, "R1 cmd in reset", cmd_o, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy_o == 0 && cmd_o == '0, "R1 idle after reset", {busy_o, cmd_o}, 0);

    for (int v = 0; v < 6; v++) begin
      logic wr;
      logic [15:0] a, d;
      wr = VECS[v][36]; a = VECS[v][35:20]; d = VECS[v][19:4];
      dly = int'(VECS[v][3:0]);
      do_txn(wr, a, d, gd, ge, gaps, lat);
      chk(gd && !ge, "R9 access completes", {gd, ge}, 2);
      chk(gaps == 0 && busy_o == 0, "R9 busy span", gaps, 0);
      chk(log_n == (wr ? 3 : 2), wr ? "R4 phase count" : "R5 phase count", log_n, wr ? 3 : 2);
      chk(log_kind[0] == 2'd0 && log_val[0] == a, "R4 R5 address phase first", {log_kind[0], log_val[0]}, {2'd0, a});
      for (int k = 0; k < log_n; k++) chk(log_setup[k], "R3 value set up before strobe", k, k);
      if (wr) begin
        chk(log_kind[1] == 2'd1 && log_val[1] == d, "R4 data phase", {log_kind[1], log_val[1]}, {2'd1, d});
        chk(log_kind[2] == 2'd3 && log_val[2] == d, "R4 write phase", {log_kind[2], log_val[2]}, {2'd3, d});
        chk(mem[a[3:0]] == d, "R4 register written", mem[a[3:0]], d);
        shadow[a[3:0]] = d;
      end else begin
        chk(log_kind[1] == 2'd2, "R5 read phase", log_kind[1], 2);
        chk(rdata_o == shadow[a[3:0]], "R5 read data", rdata_o, shadow[a[3:0]]);
      end
      @(negedge clk);
      chk(done_o == 0, "R9 done one cycle", done_o, 0);
    end
    chk(multi_stb == 0, "R2 one strobe at a time", multi_stb, 0);

    // R8 request while busy is dropped
    dly = 6;
    txn_id++;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 16'h0007; req_wdata = 16'h5A5A;
    @(negedge clk);
    req_write = 0; req_addr = 16'h0009;
    repeat (6) @(negedge clk);
    req_valid = 0;
    lat = 0;
    while (!done_o && !err_o && lat < 3000) begin @(negedge clk); lat++; end
    chk(done_o == 1, "R8 first access done", done_o, 1);
    repeat (5) @(negedge clk);
    chk(busy_o == 0, "R8 no second access", busy_o, 0);
    chk(log_n == 3 && log_kind[2] == 2'd3, "R8 only the write ran", {log_n, log_kind[2]}, {32'd3, 2'd3});
    chk(mem[7] == 16'h5A5A, "R8 write data kept", mem[7], 16'h5A5A);
    shadow[7] = 16'h5A5A;

    // R6 / R10 rising timeout
    dly = 0; no_ack = 1;
    do_txn(1'b1, 16'h0004, 16'h1234, gd, ge, gaps, lat);
    t0 = cyc - rise_cyc;
    chk(ge && !gd && err_code_o == 2'b01, "R6 rise timeout code", {ge, err_code_o}, {1'b1, 2'b01});
    chk(cmd_o[19] == 0 && cmd_o[18] == 0 && cmd_o[1:0] == 0, "R6 strobes idle", cmd_o, 0);
    chk(t0 >= (TU - 1) * C && t0 <= (TU + 1) * C, "R10 timeout window", t0, TU * C);
    repeat (40) @(negedge clk);
    chk(log_n == 1 && busy_o == 0, "R6 no later phase", log_n, 1);
    chk(mem[4] == 16'h4444, "R6 register untouched", mem[4], 16'h4444);
    no_ack = 0;
    repeat (3) @(negedge clk);

    // R7 falling timeout
    stuck = 1;
    do_txn(1'b0, 16'h0002, 16'h0000, gd, ge, gaps, lat);
    chk(ge && err_code_o == 2'b10, "R7 fall timeout code", {ge, err_code_o}, {1'b1, 2'b10});
    repeat (40) @(negedge clk);
    chk(log_n == 1 && cmd_o[18] == 0, "R7 no read phase", log_n, 1);
    stuck = 0;
    repeat (5) @(negedge clk);

    // code cleared by the next accepted access, read still works
    do_txn(1'b0, 16'h0007, 16'h0000, gd, ge, gaps, lat);
    chk(gd && err_code_o == 2'b00, "R7 code cleared on accept", err_code_o, 0);
    chk(rdata_o == 16'h5A5A, "R5 read after abort", rdata_o, 16'h5A5A);

    // R1 reset in mid-access
    no_ack = 1;
    txn_id++;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 16'h0001; req_wdata = 16'hFFFF;
    @(negedge clk);
    req_valid = 0;
    repeat (10) @(negedge clk);
    rst_n = 0;
    #1;
    chk(cmd_o == '0 && busy_o == 0, "R1 reset mid-access", {busy_o, cmd_o}, 0);
    no_ack = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(busy_o == 0 && err_o == 0, "R1 idle after second reset", {busy_o, err_o}, 0);

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=0x%0h expected=0x%0h", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule